// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This controller sits on the host side of a serial successive-approximation converter that has a single select line. A rising edge on that line starts a conversion, and the low level of the same line frames the serial transfer. When a user request arrives, the controller raises the select line and waits a fixed number of system clocks for the conversion to finish. It then runs a 16-clock serial exchange. During the exchange it shifts a 7-bit configuration word out to the converter and assembles the returned result word. When the result is ready it presents it with a one-cycle valid strobe.

The user chooses between two select-line policies.

- **Nap policy.** The select line stays high until the conversion time has elapsed. The converter naps while it waits for the transfer.
- **Stay-awake policy.** The select line drops a few clocks after the rising edge, inside the converter's early window. This keeps the converter powered, and the first result bit appears as the conversion completes.

Either way, the serial transfer begins only after the full conversion count. A configuration word with its sleep bit set puts the converter to sleep. The next request without that bit wakes the converter, and after its transfer the controller stays busy for a wake-up interval.

Top module: `sadc_ctrl`

## Requirements
- R1: While reset is held and after it is released, the select line, serial clock, serial data out, busy and valid are all low.
- R2: A start request seen while not busy raises the select line and busy on the next clock. A start request seen while busy is ignored: no new select rising edge follows it.
- R3: Under the nap policy (stay-awake low at the request), the select line stays high for exactly CONV_CYC clocks and then falls.
- R4: Under the stay-awake policy, the select line stays high for exactly EARLY_CYC clocks. The serial transfer still begins only after CONV_CYC clocks.
- R5: Each transfer produces exactly 16 serial clock pulses. Each pulse is high for SCK_DIV clocks and low for SCK_DIV clocks. The serial clock idles low and is never high while the select line is high.
- R6: The configuration word goes out MSB first, in the order single-ended, odd/sign, select bit 1, select bit 0, common, unipolar, sleep. The bit for each pulse is driven while the serial clock is low and held through its high phase. The pulses after the seventh carry 0.
- R7: The converter output is sampled as the serial clock rises, MSB first. result_o holds the first RES_BITS sampled bits, with the first bit at its MSB.
- R8: valid_o is a single-cycle pulse in the cycle the serial clock returns low after the 16th pulse. Busy is still high in that cycle and falls on the next clock, unless a wake-up wait follows.
- R9: A transfer with the sleep bit set leaves the converter asleep. The next request with the sleep bit clear runs a normal conversion and transfer, then keeps busy high for WAKE_CYC clocks after the valid cycle, and ignores start requests during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request |
| cfg_single_i | input | 1 | Single-ended input select |
| cfg_odd_i | input | 1 | Odd channel / sign select |
| cfg_sel_i | input | 2 | Channel select bits |
| cfg_com_i | input | 1 | Common-return mode |
| cfg_uni_i | input | 1 | Unipolar range |
| cfg_sleep_i | input | 1 | Put converter to sleep |
| stay_awake_i | input | 1 | Drop select early to keep the converter powered |
| busy_o | output | 1 | Controller is occupied |
| result_o | output | RES_BITS | Last result word |
| valid_o | output | 1 | One-cycle result strobe |
| adc_cs_o | output | 1 | Combined select / convert line |
| adc_sclk_o | output | 1 | Serial clock |
| adc_sdi_o | output | 1 | Configuration data to converter |
| adc_sdo_i | input | 1 | Result data from converter |

## Verification
Two events can fall in the same clock: the result-valid strobe and a new start request. The strobe fires while the sequencer is still in its transfer state, so a request presented exactly in the valid cycle must be dropped. A similar clash happens inside the wake-up wait, where a request arrives while busy is held only by the wake counter. The bench pulses start in the valid cycle of one transfer, and a few clocks into the wake-up interval of another. It then watches the select line for several clocks and judges the design correct only if no rising edge appears and busy falls at the expected time.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CFG_BITS   = 7;

  // Field order is the shift order, MSB leaves first.
  typedef struct packed {
    logic       single;
    logic       odd;
    logic [1:0] sel;
    logic       com;
    logic       uni;
    logic       sleep;
  } sadc_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_XFER,
    ST_WAKE
  } sadc_state_t;

endpackage

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int CONV_CYC  = 350,
  parameter int EARLY_CYC = 2,
  parameter int WAKE_CYC  = 6000000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  sadc_cfg_t cfg_i,
  input  logic      awake_i,
  input  logic      xfer_done_i,
  output logic      cs_o,
  output logic      go_o,
  output sadc_cfg_t cfg_o,
  output logic      busy_o
);

  localparam int MAXC = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  sadc_state_t    state_q;
  logic [CW-1:0]  cnt_q;
  logic           cs_q, go_q, asleep_q, awake_q;
  sadc_cfg_t      cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cs_q     <= 1'b0;
      go_q     <= 1'b0;
      asleep_q <= 1'b0;
      awake_q  <= 1'b0;
      cfg_q    <= '0;
    end else begin
      go_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cs_q    <= 1'b1;
            cnt_q   <= '0;
            cfg_q   <= cfg_i;
            awake_q <= awake_i;
            state_q <= ST_CONV;
          end
        end
        ST_CONV: begin
          cnt_q <= cnt_q + 1'b1;
          if (awake_q && cnt_q == CW'(EARLY_CYC - 1)) cs_q <= 1'b0;
          if (cnt_q == CW'(CONV_CYC - 1)) begin
            cs_q    <= 1'b0;
            go_q    <= 1'b1;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_done_i) begin
            cnt_q <= '0;
            if (cfg_q.sleep) begin
              asleep_q <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (asleep_q) begin
              asleep_q <= 1'b0;
              state_q  <= ST_WAKE;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(WAKE_CYC - 1)) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign cs_o   = cs_q;
  assign go_o   = go_q;
  assign cfg_o  = cfg_q;
  assign busy_o = (state_q != ST_IDLE);

  AST_CS_RISE_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_q) |-> $past(state_q == ST_IDLE && start_i)); // R2

  AST_NAP_HOLDS_CS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && !awake_q) |-> cs_q); // R3

  AST_WAKE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE && $past(state_q) != ST_WAKE) |-> $past(xfer_done_i)); // R9

endmodule

// File: rtl/sadc_shift.sv
module sadc_shift
  import sadc_pkg::*;
#(
  parameter int SCK_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go_i,
  input  sadc_cfg_t             cfg_i,
  input  logic                  sdo_i,
  output logic                  sclk_o,
  output logic                  sdi_o,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] frame_o
);

  localparam int HW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
  localparam int BW = $clog2(FRAME_BITS);

  logic                  active_q, hi_q, sclk_q, sdi_q, done_q;
  logic [HW-1:0]         half_q;
  logic [BW-1:0]         bit_q;
  logic [FRAME_BITS-1:0] tx_q, rx_q, frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      hi_q     <= 1'b0;
      sclk_q   <= 1'b0;
      sdi_q    <= 1'b0;
      done_q   <= 1'b0;
      half_q   <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      frame_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          hi_q     <= 1'b0;
          sclk_q   <= 1'b0;
          half_q   <= '0;
          bit_q    <= '0;
          tx_q     <= {cfg_i, {(FRAME_BITS-CFG_BITS){1'b0}}};
          sdi_q    <= cfg_i[CFG_BITS-1];
        end
      end else if (half_q == HW'(SCK_DIV - 1)) begin
        half_q <= '0;
        if (!hi_q) begin
          hi_q   <= 1'b1;
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[FRAME_BITS-2:0], sdo_i};
        end else begin
          hi_q   <= 1'b0;
          sclk_q <= 1'b0;
          if (bit_q == BW'(FRAME_BITS - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            frame_q  <= rx_q;
            sdi_q    <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
            sdi_q <= tx_q[FRAME_BITS-2];
          end
        end
      end else begin
        half_q <= half_q + 1'b1;
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign sdi_o   = sdi_q;
  assign done_o  = done_q;
  assign frame_o = frame_q;

  AST_SDI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> $stable(sdi_q)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int CONV_CYC  = 350,
  parameter int EARLY_CYC = 2,
  parameter int WAKE_CYC  = 6000000,
  parameter int SCK_DIV   = 2,
  parameter int RES_BITS  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                cfg_single_i,
  input  logic                cfg_odd_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic                cfg_com_i,
  input  logic                cfg_uni_i,
  input  logic                cfg_sleep_i,
  input  logic                stay_awake_i,
  output logic                busy_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                valid_o,
  output logic                adc_cs_o,
  output logic                adc_sclk_o,
  output logic                adc_sdi_o,
  input  logic                adc_sdo_i
);

  sadc_cfg_t             cfg_in, cfg_run;
  logic                  go, done;
  logic [FRAME_BITS-1:0] frame;

  assign cfg_in = '{single: cfg_single_i, odd: cfg_odd_i, sel: cfg_sel_i,
                    com: cfg_com_i, uni: cfg_uni_i, sleep: cfg_sleep_i};

  sadc_seq #(
    .CONV_CYC (CONV_CYC),
    .EARLY_CYC(EARLY_CYC),
    .WAKE_CYC (WAKE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cfg_i      (cfg_in),
    .awake_i    (stay_awake_i),
    .xfer_done_i(done),
    .cs_o       (adc_cs_o),
    .go_o       (go),
    .cfg_o      (cfg_run),
    .busy_o     (busy_o)
  );

  sadc_shift #(
    .SCK_DIV(SCK_DIV)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .go_i   (go),
    .cfg_i  (cfg_run),
    .sdo_i  (adc_sdo_i),
    .sclk_o (adc_sclk_o),
    .sdi_o  (adc_sdi_o),
    .done_o (done),
    .frame_o(frame)
  );

  assign valid_o  = done;
  assign result_o = frame[FRAME_BITS-1 -: RES_BITS];

  AST_SCLK_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    adc_sclk_o |-> !adc_cs_o); // R5

  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> busy_o); // R8

endmodule

// File: tb/sim_sadc_ctrl.sv
module sim_sadc_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CONV  = 12;
  localparam int EARLY = 2;
  localparam int WAKE  = 30;
  localparam int DIV   = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [6:0] cfg = '0;
  logic stay = 1'b0;
  logic busy, valid, cs, sclk, sdi, sdo;
  logic [15:0] result;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_ctrl #(.CONV_CYC(CONV), .EARLY_CYC(EARLY), .WAKE_CYC(WAKE),
              .SCK_DIV(DIV), .RES_BITS(16)) u0 (
    .clk(clk), .rst(rst), .start_i(start),
    .cfg_single_i(cfg[6]), .cfg_odd_i(cfg[5]), .cfg_sel_i(cfg[4:3]),
    .cfg_com_i(cfg[2]), .cfg_uni_i(cfg[1]), .cfg_sleep_i(cfg[0]),
    .stay_awake_i(stay), .busy_o(busy), .result_o(result), .valid_o(valid),
    .adc_cs_o(cs), .adc_sclk_o(sclk), .adc_sdi_o(sdi), .adc_sdo_i(sdo));

  // converter model: frame loads as select falls, shifts on serial clock fall
  logic [15:0] model_data = '0, model_frame = '0;
  always @(negedge cs)   model_frame <= model_data;
  always @(negedge sclk) model_frame <= {model_frame[14:0], 1'b0};
  assign sdo = cs ? 1'b0 : model_frame[15];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // poke: 0 none, 1 start in valid cycle, 2 start three samples after valid
  task automatic run_txn(input logic [6:0] c, input logic s, input logic [15:0] d,
                         input int exp_wake, input int poke);
    int cs_len = 0, rises = 0, hi = 0, vcnt = 0, bafter = 0, after = 0, post_cs = 0;
    logic seen_v = 1'b0, prev_s = 1'b0, aligned = 1'b0;
    logic [15:0] word = '0;
    @(negedge clk);
    model_data = d; cfg = c; stay = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      if (n > 0) @(negedge clk);
      if (start) start = 1'b0;
      if (cs && !seen_v) cs_len++;
      if (sclk && !prev_s) begin rises++; word = {word[14:0], sdi}; end
      if (sclk) hi++;
      if (seen_v) begin
        after++;
        if (busy) bafter++;
        if (poke == 2 && after == 3) start = 1'b1;
      end
      if (valid) begin
        vcnt++;
        aligned = (prev_s && !sclk && busy);
        seen_v = 1'b1;
        if (poke == 1) start = 1'b1;
      end
      if (seen_v && !busy) break;
      prev_s = sclk;
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (start) start = 1'b0;
      if (cs || busy) post_cs++;
    end
    check(s ? "R4 select high length" : "R3 select high length", cs_len, s ? EARLY : CONV);
    check("R5 serial clock pulses", rises, 16);
    check("R5 serial clock high time", hi, 16*DIV);
    check("R6 config word on sdi", word, {c, 9'b0});
    check("R7 result word", result, d);
    check("R8 single valid pulse", vcnt, 1);
    check("R8 valid aligned to last fall", aligned, 1);
    check("R9 busy after valid", bafter, exp_wake);
    if (poke != 0) check("R2 start while busy ignored", post_cs, 0);
  endtask

  // {cfg[6:0], stay, data[15:0]}
  localparam logic [23:0] VEC [5] = '{
    {7'h54, 1'b0, 16'hA5C3},
    {7'h2A, 1'b1, 16'h0001},
    {7'h7E, 1'b0, 16'hFFFF},
    {7'h40, 1'b1, 16'h8000},
    {7'h1C, 1'b0, 16'h3C5A}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cs", cs, 0);
    check("R1 reset sclk/sdi/busy/valid", {sclk, sdi, busy, valid}, 4'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {cs, sclk, sdi, busy, valid}, 5'b0);
    // R2: accepted start raises select and busy on the next clock
    cfg = 7'h00; stay = 1'b0; model_data = 16'h1234; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 select and busy rise", {cs, busy}, 2'b11);
    wait (!busy); @(negedge clk);
    for (int i = 0; i < 5; i++)
      run_txn(VEC[i][23:17], VEC[i][16], VEC[i][15:0], 0, 0);
    // R2/R8: start in the valid cycle is dropped
    run_txn(7'h22, 1'b0, 16'h0F0F, 0, 1);
    // R9: sleep, then a waking request holds busy and ignores starts
    run_txn(7'h41, 1'b0, 16'h7777, 0, 0);
    run_txn(7'h40, 1'b1, 16'h4321, WAKE, 2);
    run_txn(7'h60, 1'b0, 16'hBEEF, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule